// File: doc/BRIEF.md
# Strap-addressed SMBus slave with register file

This block is a two-wire bus slave that works entirely in the system clock domain. It samples the bus clock and data lines through two-flop synchronizers and finds their edges. It recognises start and stop conditions and shifts in the address byte. When the address matches its own, it answers the ninth clock pulse by pulling the data line low. After that it either takes a stream of bytes into a small internal register file or returns bytes from it. A register pointer steps forward after each byte and wraps around at the end of the file.

The block has no fixed slave address. It derives the address from two strap pins. While the enable strap is high, the block uses a default address. While it is low, the select strap picks one of two other addresses. The straps are captured once, when the first start condition after reset is seen. From that moment a release output stays high. This tells the surrounding logic that it may switch the two pins back to their other jobs, a PWM output and a tach input. Later activity on the pins therefore cannot move the address.

Top module: `strap_smb_slave`

## Requirements
- R1: With strap_en high at capture, the 7-bit address is 0101110 (0x2E, written 0x5C as the 8-bit byte); strap_sel has no effect.
- R2: With strap_en low at capture, strap_sel low gives address 0101100 (0x2C), strap_sel high gives 0101101 (0x2D).
- R3: The straps are captured at the first start condition after reset; strap changes after that capture do not change which address is acknowledged.
- R4: strap_release is 0 from reset until the first start condition and 1 from then on until the next reset.
- R5: A start is SDA falling while SCL is high and a stop is SDA rising while SCL is high; after a stop the slave leaves SDA released (sda_oe_n = 1).
- R6: The first byte after a start carries the address MSB first, then the direction bit (0 = master writes, 1 = master reads). On a match the slave pulls SDA low for the ninth pulse. Otherwise it releases SDA and acknowledges nothing until the next start.
- R7: In a write, the slave acknowledges every data byte. The first data byte sets the pointer to its low PTR_W bits. Each later byte is stored at the pointer, and the pointer then advances by one modulo 2^PTR_W, so bursts of any length wrap.
- R8: In a read, the slave sends the register at the pointer MSB first and then advances the pointer. Registers reset to 0. A master ACK (SDA low on the ninth pulse) fetches the next byte. A master NACK (SDA high) makes the slave release SDA until the next start.
- R9: A repeated start without a stop restarts the address phase, so a pointer write followed by a repeated start and a read returns data from the new pointer.
- R10: The slave changes its SDA drive only while SCL is low, never during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line (0 pulls low) |
| strap_en | input | 1 | Address-enable strap; high selects the default address |
| strap_sel | input | 1 | Address-select strap, used when strap_en is low |
| strap_release | output | 1 | High once the address is captured; the strap pins may return to their other functions |

## Verification
Capturing the strap address and detecting the first start condition happen on the same clock edge. The strap pins are asynchronous, so a strap change that lands right after the SDA fall of that start is the hard case. The bench flips both straps four cycles after the first SDA fall, which is still inside the start hold time and after the synchronized start has been registered. It then judges the outcome by which addresses the slave acknowledges: the pre-flip address must be acknowledged and the post-flip address refused. A reference model checks the release output and the idle SDA state on every clock.

// File: rtl/strap_smb_slave.sv
module strap_smb_slave #(
  parameter int         PTR_W     = 3,
  parameter logic [6:0] ADDR_DEF  = 7'h2E,
  parameter logic [6:0] ADDR_SEL0 = 7'h2C,
  parameter logic [6:0] ADDR_SEL1 = 7'h2D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe_n,
  input  logic strap_en,
  input  logic strap_sel,
  output logic strap_release
);
  localparam int NREG = 1 << PTR_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WDATA, ST_RDATA} st_t;

  st_t              state;
  logic [2:0]       scl_s, sda_s;
  logic [3:0]       bitcnt;
  logic [7:0]       shift, tx;
  logic [PTR_W-1:0] ptr;
  logic [6:0]       addr_q;
  logic [7:0]       regs [NREG];
  logic             pull, rw, first, mack, locked;

  wire scl      = scl_s[1];
  wire sda      = sda_s[1];
  wire scl_rise = scl & ~scl_s[2];
  wire scl_fall = ~scl & scl_s[2];
  wire start    = scl & scl_s[2] & sda_s[2] & ~sda;
  wire stop     = scl & scl_s[2] & ~sda_s[2] & sda;
  wire [6:0] strap_addr = strap_en ? ADDR_DEF : (strap_sel ? ADDR_SEL1 : ADDR_SEL0);

  assign sda_oe_n      = ~pull;
  assign strap_release = locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      scl_s  <= 3'b111;
      sda_s  <= 3'b111;
      bitcnt <= '0;
      shift  <= '0;
      tx     <= '0;
      ptr    <= '0;
      addr_q <= '0;
      pull   <= 1'b0;
      rw     <= 1'b0;
      first  <= 1'b0;
      mack   <= 1'b0;
      locked <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      scl_s <= {scl_s[1:0], scl_in};
      sda_s <= {sda_s[1:0], sda_in};
      if (start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        pull   <= 1'b0;
        if (!locked) begin
          locked <= 1'b1;
          addr_q <= strap_addr;
        end
      end else if (stop) begin
        state <= ST_IDLE;
        pull  <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shift  <= {shift[6:0], sda};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            mack   <= ~sda;
            bitcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (state)
              ST_ADDR:
                if (shift[7:1] == addr_q) begin
                  pull <= 1'b1;
                  rw   <= shift[0];
                end else begin
                  state <= ST_IDLE;
                end
              ST_WDATA: begin
                pull <= 1'b1;
                if (first) begin
                  ptr   <= shift[PTR_W-1:0];
                  first <= 1'b0;
                end else begin
                  regs[ptr] <= shift;
                  ptr       <= ptr + 1'b1;
                end
              end
              ST_RDATA: pull <= 1'b0;
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            case (state)
              ST_ADDR:
                if (rw) begin
                  state <= ST_RDATA;
                  tx    <= regs[ptr];
                  pull  <= ~regs[ptr][7];
                  ptr   <= ptr + 1'b1;
                end else begin
                  state <= ST_WDATA;
                  first <= 1'b1;
                  pull  <= 1'b0;
                end
              ST_WDATA: pull <= 1'b0;
              ST_RDATA:
                if (mack) begin
                  tx   <= regs[ptr];
                  pull <= ~regs[ptr][7];
                  ptr  <= ptr + 1'b1;
                end else begin
                  state <= ST_IDLE;
                  pull  <= 1'b0;
                end
              default: ;
            endcase
          end else if (state == ST_RDATA && bitcnt != 4'd0) begin
            tx   <= {tx[6:0], 1'b0};
            pull <= ~tx[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/strap_smb_slave_chk.sv
module strap_smb_slave_chk #(
  parameter logic [6:0] A_DEF  = 7'h2E,
  parameter logic [6:0] A_SEL0 = 7'h2C,
  parameter logic [6:0] A_SEL1 = 7'h2D
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s1,
  input logic       sda_oe_n,
  input logic       strap_release,
  input logic       idle,
  input logic [6:0] addr_q
);
  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    strap_release |=> strap_release); // R4

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_release) |-> $stable(addr_q)); // R3

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_n) |-> !$past(scl_s1)); // R10

  AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> sda_oe_n); // R6

  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    strap_release |-> (addr_q == A_DEF || addr_q == A_SEL0 || addr_q == A_SEL1)); // R2
endmodule

bind strap_smb_slave strap_smb_slave_chk #(
  .A_DEF(ADDR_DEF), .A_SEL0(ADDR_SEL0), .A_SEL1(ADDR_SEL1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s1(scl_s[1]), .sda_oe_n(sda_oe_n),
  .strap_release(strap_release), .idle(state == ST_IDLE), .addr_q(addr_q)
);

// File: tb/sim_strap_smb_slave.sv
`timescale 1ns/1ps
module sim_strap_smb_slave;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic strap_en = 1'b0, strap_sel = 1'b0;
  logic sda_oe_n, strap_release;
  wire  sda_line = m_sda & sda_oe_n;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [7:0] mreg [8];
  int mptr = 0;
  logic first_seen = 1'b0, exp_rel = 1'b0, rel_dc = 1'b0, m_idle = 1'b0;
  logic flip_en = 1'b0, flip_sel = 1'b0, do_flip = 1'b0;
  logic [7:0] wdat [$];

  always #2.5 clk = ~clk;

  strap_smb_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe_n(sda_oe_n),
    .strap_en(strap_en), .strap_sel(strap_sel), .strap_release(strap_release));

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!rel_dc) check("R4 release", strap_release, exp_rel);
      if (m_idle) check("R5 idle sda", sda_oe_n, 1);
    end
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic s);
    logic s0;
    m_sda = b; wq;
    m_scl = 1'b1; repeat (2) @(negedge clk);
    s0 = sda_line; repeat (Q - 2) @(negedge clk);
    s = sda_line;
    check("R10 sda stable while scl high", s, s0);
    m_scl = 1'b0; wq;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitx(d[i], s);
    bitx(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic ack_m, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, s); d[i] = s; end
    bitx(~ack_m, s);
  endtask

  task automatic bstart;
    m_idle = 1'b0;
    if (!first_seen) rel_dc = 1'b1;
    m_sda = 1'b1; wq;
    m_scl = 1'b1; wq;
    m_sda = 1'b0;
    if (do_flip) begin
      repeat (4) @(negedge clk);
      strap_en = flip_en; strap_sel = flip_sel; do_flip = 1'b0;
      repeat (Q - 4) @(negedge clk);
    end else wq;
    m_scl = 1'b0; wq;
    if (!first_seen) begin first_seen = 1'b1; exp_rel = 1'b1; rel_dc = 1'b0; end
  endtask

  task automatic bstop;
    m_sda = 1'b0; wq;
    m_scl = 1'b1; wq;
    m_sda = 1'b1; wq;
    m_idle = 1'b1;
  endtask

  task automatic do_reset(input logic en, input logic sel);
    rst_n = 1'b0; m_idle = 1'b0; rel_dc = 1'b1;
    strap_en = en; strap_sel = sel;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    first_seen = 1'b0; exp_rel = 1'b0; rel_dc = 1'b0; mptr = 0;
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    @(negedge clk);
    check("R5 reset sda", sda_oe_n, 1);
    check("R4 reset release", strap_release, 0);
    m_idle = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic exp_ack, input string tag);
    logic ack;
    bstart;
    wbyte({a, 1'b0}, ack);
    check({tag, " addr ack"}, ack, exp_ack);
    wbyte(p, ack);
    check(exp_ack ? "R7 ptr ack" : "R6 no ack after mismatch", ack, exp_ack);
    if (exp_ack) begin
      mptr = p % 8;
      foreach (wdat[k]) begin
        wbyte(wdat[k], ack);
        check("R7 data ack", ack, 1);
        mreg[mptr] = wdat[k];
        mptr = (mptr + 1) % 8;
      end
    end
    bstop;
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input logic set_ptr, input logic [7:0] p);
    logic ack;
    logic [7:0] d;
    bstart;
    if (set_ptr) begin
      wbyte({a, 1'b0}, ack);
      check("R6 addr ack", ack, 1);
      wbyte(p, ack);
      check("R7 ptr ack", ack, 1);
      mptr = p % 8;
      bstart;
    end
    wbyte({a, 1'b1}, ack);
    check(set_ptr ? "R9 ack after repeated start" : "R8 read addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, d);
      check(set_ptr ? "R9 R8 read data" : "R8 read data", d, mreg[mptr]);
      mptr = (mptr + 1) % 8;
    end
    check("R8 released after nack", sda_oe_n, 1);
    bstop;
  endtask

  initial begin
    // R2: enable low, select high -> 0x2D; first transaction is a miss to 0x2C
    do_reset(1'b0, 1'b1);
    wdat = {};
    do_write(7'h2C, 8'h00, 1'b0, "R2 R6 mismatch");
    strap_en = 1'b1; strap_sel = 1'b0;
    wdat = {8'hA1, 8'hB2, 8'hC3};
    do_write(7'h2D, 8'h06, 1'b1, "R3 frozen");        // R7 wrap 6,7,0
    do_read(7'h2D, 3, 1'b1, 8'h06);                   // R9
    wdat = {};
    do_write(7'h2E, 8'h00, 1'b0, "R3 strap change ignored");
    do_read(7'h2D, 2, 1'b0, 8'h00);                   // R8 continues at 1, reset zeros
    wdat = {};
    for (int i = 0; i < 20; i++) wdat.push_back(8'(i * 7 + 3));
    do_write(7'h2D, 8'hF8, 1'b1, "R7 burst");         // ptr low bits = 0
    do_read(7'h2D, 10, 1'b1, 8'h03);
    // R1: enable high, select ignored
    do_reset(1'b1, 1'b1);
    wdat = {};
    do_write(7'h2D, 8'h00, 1'b0, "R1 sel ignored");
    wdat = {8'h5A, 8'h3C};
    do_write(7'h2E, 8'h01, 1'b1, "R1 default addr");
    do_read(7'h2E, 2, 1'b1, 8'h01);
    // R3: straps flipped just after the first start's SDA fall
    do_reset(1'b0, 1'b0);
    flip_en = 1'b1; flip_sel = 1'b1; do_flip = 1'b1;
    wdat = {8'h77};
    do_write(7'h2C, 8'h04, 1'b1, "R3 R2 capture at start");
    wdat = {};
    do_write(7'h2E, 8'h00, 1'b0, "R3 post-flip addr refused");
    do_read(7'h2C, 1, 1'b1, 8'h04);
    repeat (20) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule